// File: doc/BRIEF.md
# Periodic Tick Timer

This block is a down-counting timer meant to give an operating system a steady heartbeat. Software loads a period into a reload register, sets the run bit in the control register, and the counter then steps down from that value to zero, reloads itself, and starts again without further attention. Each pass through zero latches an expiry flag and, when interrupts are allowed, pulses the interrupt output for one clock.

The counter advances either on every clock or once every eighth clock, chosen by a control bit, so long periods are reachable without a wider counter. Three registers are reached through a small read/write port with a two-bit select: control/status at select 0, reload at select 1 and current count at select 2. Reads are combinational. A read of control clears the expiry flag. A write to the current-count register restarts the count from zero.

Top module: `tick_timer`

## Requirements
- R1: After reset the control, reload and current-count registers all read zero and `irq` is low.
- R2: Control bits: bit 0 runs the counter, bit 1 allows the interrupt, bit 2 selects the full clock rate (1) or the divided rate (0), bit 16 is the read-only expiry flag. Written bits 0 to 2 read back unchanged.
- R3: On each counting tick a count of zero loads the reload value and any other count decreases by one. The current-count register (select 2) shows the count, which holds while bit 0 is clear.
- R4: With full-rate counting and the interrupt allowed, `irq` is high for exactly one clock on the edge where the count steps from 1 to 0, so interrupts repeat every reload+1 clocks.
- R5: With divided-rate counting a tick occurs every eighth clock, the first one eight clocks after the run bit is set; interrupts then repeat every 8 × (reload+1) clocks.
- R6: A reload value of zero produces no expiry: the count stays at zero, the flag stays clear and `irq` stays low.
- R7: With bit 1 clear an expiry sets the flag but `irq` stays low.
- R8: A read of the control register returns the flag as it was and clears it afterwards; a second read returns bit 16 as zero.
- R9: Any write to the current-count register, whatever its data, sets the count to zero and clears the expiry flag.
- R10: The reload register keeps only its low 24 bits and reads the upper bits as zero; select 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 2 | Register select: 0 control, 1 reload, 2 current count |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_rd | input | 1 | Read strobe; clears the expiry flag when control is selected |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | One-clock interrupt pulse on expiry |

## Verification
The bench builds the block with its default parameters: a 24-bit counter, a divide ratio of 8 and a 32-bit data port. Small reload values of 0 to 5 let many full periods and both clock rates fit into a short run, and every expected interrupt cycle and stopped count is derived from the tick count since the run bit was set. The all-ones reload write brings the 24-bit width limit within reach.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int unsigned CNT_W_DEF  = 24;
    localparam int unsigned DIV_DEF    = 8;
    localparam int unsigned DATA_W_DEF = 32;
    localparam int unsigned SEL_W      = 2;

    localparam int unsigned BIT_RUN    = 0;
    localparam int unsigned BIT_IRQEN  = 1;
    localparam int unsigned BIT_FAST   = 2;
    localparam int unsigned BIT_FLAG   = 16;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL    = 2'd0,
        SEL_RELOAD  = 2'd1,
        SEL_CURRENT = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic fast;
        logic irq_en;
        logic run;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [DATA_W_DEF-1:0] w);
        ctrl_t c;
        c.run    = w[BIT_RUN];
        c.irq_en = w[BIT_IRQEN];
        c.fast   = w[BIT_FAST];
        return c;
    endfunction

endpackage

// File: rtl/tick_prescale.sv
module tick_prescale #(
    parameter int unsigned DIV = tick_pkg::DIV_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fast,
    output logic tick
);
    localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] phase;

    assign tick = run && (fast || (phase == LAST));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            phase <= '0;
        end else if (phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // R5
    slow_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !fast && run && DIV > 1) |=> !tick || fast);

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int unsigned CNT_W = tick_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign expire = tick && !clr && (count == ONE);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (tick) begin
            if (count == '0) begin
                count <= reload;
            end else begin
                count <= count - ONE;
            end
        end
    end

    // R3
    load_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && count == '0) |=> count == $past(reload));

    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr && count != '0) |=> count == $past(count) - ONE);

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> count == '0);

endmodule

// File: rtl/tick_regs.sv
module tick_regs #(
    parameter int unsigned CNT_W  = tick_pkg::CNT_W_DEF,
    parameter int unsigned DATA_W = tick_pkg::DATA_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [tick_pkg::SEL_W-1:0] sel,
    input  logic                       wr,
    input  logic                       rd,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [CNT_W-1:0]           count,
    input  logic                       expire,
    output tick_pkg::ctrl_t            ctrl,
    output logic [CNT_W-1:0]           reload,
    output logic                       clr_cnt,
    output logic                       irq,
    output logic [DATA_W-1:0]          rdata
);
    import tick_pkg::*;

    reg_sel_e rsel;
    logic     flag;
    logic     rd_ctrl;

    assign rsel    = reg_sel_e'(sel);
    assign clr_cnt = wr && (rsel == SEL_CURRENT);
    assign rd_ctrl = rd && (rsel == SEL_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl   <= '0;
            reload <= '0;
            flag   <= 1'b0;
            irq    <= 1'b0;
        end else begin
            if (wr && rsel == SEL_CTRL) begin
                ctrl <= ctrl_from_word(DATA_W_DEF'(wdata));
            end
            if (wr && rsel == SEL_RELOAD) begin
                reload <= wdata[CNT_W-1:0];
            end
            if (expire) begin
                flag <= 1'b1;
            end else if (clr_cnt || rd_ctrl) begin
                flag <= 1'b0;
            end
            irq <= expire && ctrl.irq_en;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (rsel)
            SEL_CTRL: begin
                rdata[BIT_RUN]   = ctrl.run;
                rdata[BIT_IRQEN] = ctrl.irq_en;
                rdata[BIT_FAST]  = ctrl.fast;
                rdata[BIT_FLAG]  = flag;
            end
            SEL_RELOAD:  rdata[CNT_W-1:0] = reload;
            SEL_CURRENT: rdata[CNT_W-1:0] = count;
            default:     rdata = '0;
        endcase
    end

    // R4
    irq_single_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R7
    irq_has_flag_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> flag);

    // R8
    flag_read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_ctrl && !expire) |=> !flag);

endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int unsigned CNT_W  = tick_pkg::CNT_W_DEF,
    parameter int unsigned DIV    = tick_pkg::DIV_DEF,
    parameter int unsigned DATA_W = tick_pkg::DATA_W_DEF
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [tick_pkg::SEL_W-1:0] bus_sel,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       irq
);
    tick_pkg::ctrl_t  ctrl;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] count;
    logic             tick;
    logic             clr_cnt;
    logic             expire;

    tick_prescale #(.DIV(DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl.run),
        .fast (ctrl.fast),
        .tick (tick)
    );

    tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .clr    (clr_cnt),
        .reload (reload),
        .count  (count),
        .expire (expire)
    );

    tick_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .sel     (bus_sel),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .wdata   (bus_wdata),
        .count   (count),
        .expire  (expire),
        .ctrl    (ctrl),
        .reload  (reload),
        .clr_cnt (clr_cnt),
        .irq     (irq),
        .rdata   (bus_rdata)
    );

    // R6
    zero_reload_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (reload == '0 && count == '0 && !bus_wr) |=> !expire && count == '0);

    // R3
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !bus_wr) |=> $stable(count));

endmodule

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_sel = 2'd0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int exp_q[$];
    bit done = 0;

    tick_timer u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: pops expected interrupt cycles (R4, R5, R7)
    always @(negedge clk) begin
        if (!rst && irq && !done) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R4 actual=irq at cycle %0d expected=no irq", cyc);
            end else begin
                int e;
                e = exp_q.pop_front();
                if (e != cyc) begin
                    errors++;
                    $display("FAIL R4 actual=irq at cycle %0d expected=cycle %0d", cyc, e);
                end
            end
        end
    end

    task automatic bus_write(input logic [1:0] sel, input logic [31:0] d);
        bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] sel, output logic [31:0] d);
        bus_sel = sel; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // driver: starts the timer, predicts interrupts, stops it, returns the expected count
    task automatic run_timer(input int rl, input logic [31:0] cw, input int nwait,
                             output int exp_cnt, output bit exp_flag);
        int c, step, n;
        c = cyc;
        step = cw[2] ? 1 : 8;
        n = (nwait + 1) / step;
        exp_flag = 0;
        for (int j = 1; j <= n; j++) begin
            if (rl > 0 && ((j - 1) % (rl + 1)) == rl) begin
                exp_flag = 1;
                if (cw[1]) exp_q.push_back(c + 1 + j * step);
            end
        end
        exp_cnt = (n == 0) ? 0 : rl - ((n - 1) % (rl + 1));
        bus_write(2'd0, cw);
        repeat (nwait) @(negedge clk);
        bus_write(2'd0, 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int ec;
        bit ef;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        bus_read(2'd0, d); check("R1 ctrl", d, 32'h0);
        bus_read(2'd1, d); check("R1 reload", d, 32'h0);
        bus_read(2'd2, d); check("R1 current", d, 32'h0);

        // R10 reload width, unmapped select
        bus_write(2'd1, 32'hFFFF_FFFF);
        bus_read(2'd1, d); check("R10 reload mask", d, 32'h00FF_FFFF);
        bus_read(2'd3, d); check("R10 unmapped", d, 32'h0);

        // R2 control readback without running
        bus_write(2'd0, 32'h6);
        bus_read(2'd0, d); check("R2 ctrl readback", d, 32'h6);
        bus_write(2'd0, 32'h0);

        // R4 full rate, reload 3
        bus_write(2'd1, 32'd3);
        bus_write(2'd2, 32'h0);
        run_timer(3, 32'h7, 20, ec, ef);
        bus_read(2'd2, d); check("R3 stopped count full", d, ec);
        bus_read(2'd0, d); check("R8 flag seen", d, ef ? 32'h10000 : 32'h0);
        bus_read(2'd0, d); check("R8 flag cleared", d, 32'h0);
        check("R4 all irqs seen", exp_q.size(), 0);

        // R5 divided rate, reload 2
        bus_write(2'd1, 32'd2);
        bus_write(2'd2, 32'h0);
        run_timer(2, 32'h3, 60, ec, ef);
        bus_read(2'd2, d); check("R5 stopped count divided", d, ec);
        check("R5 all irqs seen", exp_q.size(), 0);
        bus_read(2'd0, d);

        // R7 interrupt disabled, flag still set
        bus_write(2'd1, 32'd4);
        bus_write(2'd2, 32'h0);
        run_timer(4, 32'h5, 15, ec, ef);
        bus_read(2'd0, d); check("R7 flag without irq", d, 32'h10000);
        bus_read(2'd0, d); check("R8 second read", d, 32'h0);

        // R9 write to current clears count and flag
        bus_write(2'd1, 32'd5);
        bus_write(2'd2, 32'h0);
        run_timer(5, 32'h5, 13, ec, ef);
        bus_read(2'd2, d); check("R3 count before clear", d, ec);
        bus_write(2'd2, 32'h00AB_CDEF);
        bus_read(2'd2, d); check("R9 count cleared", d, 32'h0);
        bus_read(2'd0, d); check("R9 flag cleared", d, 32'h0);

        // R6 reload zero: no events
        bus_write(2'd1, 32'd0);
        run_timer(0, 32'h7, 30, ec, ef);
        bus_read(2'd2, d); check("R6 count stays zero", d, 32'h0);
        bus_read(2'd0, d); check("R6 no flag", d, 32'h0);
        check("R6 queue empty", exp_q.size(), 0);

        repeat (4) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule